// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the shared timing reference for a two-channel pulse-width modulator. A 16-bit counter steps once per prescaled tick. The prescaled tick rate is the system clock divided by a power-of-two stage multiplied by an even-step stage. The counter can count up and wrap, count down and reload, count up then down in a triangle, or hold its value. One period register is shared by both channels, and it can be written straight through or staged in a shadow copy that takes effect when the count reaches zero. Downstream compare logic uses the count value, a direction flag, and two event strobes that mark the zero point and the period point.

Software uses a two-entry write port. Address 0 holds the control word and address 1 holds the period. The run field of the control word drives a four-state run machine. `RS_HALT` is the stopped state. `RS_FREE` counts without end. `RS_LAST` takes one more count step. `RS_ENDING` counts until the current period cycle completes.

The transitions are as follows. Any of the four states goes to `RS_FREE` on a control write whose run field is 1x. `RS_FREE` and `RS_ENDING` go to `RS_LAST` on a write of 00. `RS_FREE` and `RS_LAST` go to `RS_ENDING` on a write of 01. `RS_LAST` goes to `RS_HALT` on its next tick. `RS_ENDING` goes to `RS_HALT` on the tick whose step lands the count on zero. A stop write that arrives while the machine is in `RS_HALT` leaves it in `RS_HALT`.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, both event strobes and the direction flag are low, and the counter is stopped. The control word resets to 16'h0003 (freeze, stop-next, prescale factor 1) and the period resets to 0.
- R2: Writes with wr_addr=0 load the control word. Its fields are: count mode in bits 1:0, period-load select in bit 3, high-speed divisor h in bits 9:7, clock divisor c in bits 12:10, and run field in bits 15:14. Writes with wr_addr=1 load the period.
- R3: In mode 00 (up) the count advances by 1 on each tick and goes from the period value back to 0, with dir_down low.
- R4: In mode 01 (down) the count decreases by 1 on each tick and reloads the period value after 0, with dir_down high once it has stepped.
- R5: In mode 10 (up-down) the count rises to the period value, then falls to 0, then rises again. dir_down is high while falling.
- R6: A tick occurs once every 2^c * (h==0 ? 1 : 2h) clocks, and the count moves only on ticks. A control write restarts the divider, and the first tick comes that many clocks after the write edge.
- R7: With bit 3 set, a period write takes effect in the next cycle.
- R8: With bit 3 clear, a period write goes to a shadow copy. The shadow copy becomes the active period on the step that brings the count to zero.
- R9: While the counter runs, zero_evt is high exactly when the count is 0, and prd_evt is high exactly when the count equals the active period. Both are low while stopped.
- R10: Run field 00 written while running allows exactly one further count step after the write edge, after which the count holds.
- R11: Run field 01 written while running lets counting continue until a step lands on 0, after which the count holds at 0.
- R12: Mode 11 (freeze) holds the count while the run state is unchanged.
- R13: Run field 1x written while stopped starts counting from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control word, 1 selects period |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| dir_down | output | 1 | High while the counter is stepping downward |
| zero_evt | output | 1 | Count is zero while running |
| prd_evt | output | 1 | Count equals the active period while running |

## Verification
Every result is registered once, so a write or tick at one clock edge becomes visible in the following cycle. The events are combinational on the registered count and therefore line up with it exactly. With a divisor of 1 the first count step lands one edge after the starting control write. With a divisor of F it lands F edges after that write, and each count value then persists for F cycles. A stop-next write moves the count at its own edge and once more at the next tick. The bench drives inputs and samples outputs only on falling clock edges, and it compares sample k after a write with a value computed from k, the period and the divisor.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;
    typedef enum logic [1:0] {
        MODE_UP     = 2'b00,
        MODE_DOWN   = 2'b01,
        MODE_UPDN   = 2'b10,
        MODE_FREEZE = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RS_HALT,
        RS_FREE,
        RS_LAST,
        RS_ENDING
    } run_state_e;

    localparam int MODE_LSB  = 0;
    localparam int IMM_BIT   = 3;
    localparam int HSP_LSB   = 7;
    localparam int CDIV_LSB  = 10;
    localparam int RUN_LSB   = 14;
    localparam int DIV_W     = 3;
    localparam logic [15:0] CTRL_RESET = 16'h0003;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear,
    input  logic [DIV_W-1:0] hsp,
    input  logic [DIV_W-1:0] cdiv,
    output logic             tick
);
    localparam int HS_MAX = (1 << DIV_W) - 1;
    localparam int FACT_W = $clog2((1 << HS_MAX) * 2 * HS_MAX + 1);

    logic [FACT_W-1:0] pow2, hs_mul, factor_m1, pcnt;

    always_comb begin
        pow2      = FACT_W'(1) << cdiv;
        hs_mul    = (hsp == '0) ? FACT_W'(1) : FACT_W'({hsp, 1'b0});
        factor_m1 = FACT_W'(pow2 * hs_mul) - FACT_W'(1);
        tick      = enable && (pcnt == factor_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clear || !enable || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + FACT_W'(1);
    end

    // R6
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && factor_m1 != '0) |=> !tick);
endmodule

// File: rtl/pwm_period_reg.sv
module pwm_period_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_imm,
    input  logic [W-1:0] wr_data,
    input  logic         load_zero,
    output logic [W-1:0] active_prd
);
    logic [W-1:0] shadow_prd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_prd <= '0;
            active_prd <= '0;
        end else begin
            if (wr_en)
                shadow_prd <= wr_data;
            if (wr_en && wr_imm)
                active_prd <= wr_data;
            else if (load_zero)
                active_prd <= shadow_prd;
        end
    end

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_imm && !load_zero) |=> $stable(active_prd));
endmodule

// File: rtl/pwm_cnt_fsm.sv
module pwm_cnt_fsm
    import pwm_tbase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_wr,
    input  logic [1:0]   wr_run,
    input  cnt_mode_e    mode,
    input  logic         tick,
    input  logic [W-1:0] prd,
    output logic [W-1:0] cnt,
    output logic         dir_down,
    output logic         running,
    output logic         zero_load
);
    run_state_e state, state_nxt;
    logic [W-1:0] cnt_nxt;
    logic         dir_nxt, step;

    assign running   = (state != RS_HALT);
    assign step      = running && tick && (mode != MODE_FREEZE);
    assign zero_load = step && (cnt_nxt == '0);

    always_comb begin
        dir_nxt = dir_down;
        cnt_nxt = cnt;
        unique case (mode)
            MODE_UP: begin
                dir_nxt = 1'b0;
                cnt_nxt = (cnt >= prd) ? '0 : cnt + W'(1);
            end
            MODE_DOWN: begin
                dir_nxt = 1'b1;
                cnt_nxt = (cnt == '0) ? prd : cnt - W'(1);
            end
            MODE_UPDN: begin
                if (!dir_down && cnt >= prd)
                    dir_nxt = 1'b1;
                else if (dir_down && cnt == '0)
                    dir_nxt = 1'b0;
                if (prd == '0)
                    cnt_nxt = '0;
                else if (dir_nxt)
                    cnt_nxt = cnt - W'(1);
                else
                    cnt_nxt = cnt + W'(1);
            end
            MODE_FREEZE: ;
        endcase
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RS_HALT: begin
                if (ctrl_wr && wr_run[1]) state_nxt = RS_FREE;
            end
            RS_FREE: begin
                if (ctrl_wr && !wr_run[1])
                    state_nxt = wr_run[0] ? RS_ENDING : RS_LAST;
            end
            RS_LAST: begin
                if (ctrl_wr)
                    state_nxt = wr_run[1] ? RS_FREE : (wr_run[0] ? RS_ENDING : RS_LAST);
                else if (tick)
                    state_nxt = RS_HALT;
            end
            RS_ENDING: begin
                if (ctrl_wr)
                    state_nxt = wr_run[1] ? RS_FREE : (wr_run[0] ? RS_ENDING : RS_LAST);
                else if (zero_load)
                    state_nxt = RS_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RS_HALT;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            dir_down <= 1'b0;
        end else if (step) begin
            cnt      <= cnt_nxt;
            dir_down <= dir_nxt;
        end
    end

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_UP && cnt < prd) |=> (cnt == $past(cnt) + W'(1)));
    // R3
    up_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_UP) |=> !dir_down);
    // R12
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREEZE) |=> $stable(cnt));
    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_HALT) |=> $stable(cnt));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tbase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_addr,
    input  logic [15:0]  wr_data,
    output logic [W-1:0] count,
    output logic         dir_down,
    output logic         zero_evt,
    output logic         prd_evt
);
    logic [15:0]  ctrl;
    logic         ctrl_wr, prd_wr, tick, running, zero_load;
    logic [W-1:0] active_prd;
    cnt_mode_e    mode;

    assign ctrl_wr = wr_en && !wr_addr;
    assign prd_wr  = wr_en && wr_addr;
    assign mode    = cnt_mode_e'(ctrl[MODE_LSB +: 2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl <= CTRL_RESET;
        else if (ctrl_wr)
            ctrl <= wr_data;
    end

    pwm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (running),
        .clear  (ctrl_wr),
        .hsp    (ctrl[HSP_LSB +: DIV_W]),
        .cdiv   (ctrl[CDIV_LSB +: DIV_W]),
        .tick   (tick)
    );

    pwm_period_reg #(.W(W)) u_prd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (prd_wr),
        .wr_imm     (ctrl[IMM_BIT]),
        .wr_data    (wr_data[W-1:0]),
        .load_zero  (zero_load),
        .active_prd (active_prd)
    );

    pwm_cnt_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wr_run    (wr_data[RUN_LSB +: 2]),
        .mode      (mode),
        .tick      (tick),
        .prd       (active_prd),
        .cnt       (count),
        .dir_down  (dir_down),
        .running   (running),
        .zero_load (zero_load)
    );

    assign zero_evt = running && (count == '0);
    assign prd_evt  = running && (count == active_prd);

    // R9
    evt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running) |-> (!zero_evt && !prd_evt));
endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        dir_down, zero_evt, prd_evt;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pwm_timebase i_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .dir_down(dir_down),
        .zero_evt(zero_evt), .prd_evt(prd_evt)
    );

    task automatic check(string req, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // stopped, immediate-load, freeze; load period; then start with ctrl
    task automatic setup(input logic [15:0] prd, input logic [15:0] run_ctrl);
        do_reset();
        wr(1'b0, 16'h000B);
        wr(1'b1, prd);
        wr(1'b0, run_ctrl);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", count, 0);
        check("R1 zero_evt", zero_evt, 0);
        check("R1 prd_evt", prd_evt, 0);
        check("R1 dir", dir_down, 0);
        repeat (3) @(negedge clk);
        check("R1 held", count, 0);
    endtask

    task automatic t_up();
        setup(16'd4, 16'hC008);
        for (int i = 0; i < 12; i++) begin
            if (i > 0) @(negedge clk);
            check("R3 R7 R13 up count", count, i % 5);
            check("R9 zero_evt up", zero_evt, (i % 5) == 0);
            check("R9 prd_evt up", prd_evt, (i % 5) == 4);
            check("R3 dir", dir_down, 0);
        end
    endtask

    task automatic t_down();
        setup(16'd3, 16'hC009);
        for (int i = 0; i < 10; i++) begin
            if (i > 0) @(negedge clk);
            check("R4 down count", count, (4 - i % 4) % 4);
            if (i > 0) check("R4 dir", dir_down, 1);
            check("R9 prd_evt down", prd_evt, ((4 - i % 4) % 4) == 3);
        end
    endtask

    task automatic t_updown();
        setup(16'd3, 16'hC00A);
        for (int i = 0; i < 14; i++) begin
            int m;
            m = i % 6;
            if (i > 0) @(negedge clk);
            check("R5 updown count", count, (m <= 3) ? m : 6 - m);
            if (i > 0) check("R5 dir", dir_down, (m >= 4) || (m == 0));
            check("R9 zero_evt updown", zero_evt, ((m <= 3) ? m : 6 - m) == 0);
        end
    endtask

    task automatic t_presc(input logic [2:0] c, input logic [2:0] h);
        int f;
        f = (1 << c) * ((h == 0) ? 1 : 2 * h);
        setup(16'd2, 16'hC008 | (16'(c) << 10) | (16'(h) << 7));
        for (int i = 0; i < 4 * f; i++) begin
            if (i > 0) @(negedge clk);
            check("R6 R2 prescaled count", count, (i / f) % 3);
        end
    endtask

    task automatic t_shadow();
        do_reset();
        wr(1'b0, 16'h000B);
        wr(1'b1, 16'd2);
        wr(1'b0, 16'hC000);
        wr(1'b1, 16'd4);
        for (int i = 1; i < 14; i++) begin
            if (i > 1) @(negedge clk);
            check("R8 shadow count", count, (i <= 2) ? i : (i - 3) % 5);
        end
    endtask

    task automatic t_stop_next();
        setup(16'd9, 16'hC008);
        repeat (3) @(negedge clk);
        check("R10 pre", count, 3);
        wr(1'b0, 16'h0008);
        check("R10 write step", count, 4);
        @(negedge clk);
        check("R10 final step", count, 5);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R10 held", count, 5);
            check("R9 no evt when halted", prd_evt, 0);
        end
    endtask

    task automatic t_stop_end();
        setup(16'd3, 16'hC008);
        @(negedge clk);
        wr(1'b0, 16'h4008);
        check("R11 step", count, 2);
        @(negedge clk);
        check("R11 step", count, 3);
        @(negedge clk);
        check("R11 end", count, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R11 held at zero", count, 0);
            check("R9 zero_evt halted", zero_evt, 0);
        end
    endtask

    task automatic t_freeze();
        setup(16'd5, 16'hC008);
        repeat (2) @(negedge clk);
        wr(1'b0, 16'hC00B);
        check("R12 last step", count, 3);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R12 frozen", count, 3);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_up();
        t_down();
        t_updown();
        t_presc(3'd1, 3'd1);
        t_presc(3'd0, 3'd3);
        t_presc(3'd2, 3'd0);
        t_shadow();
        t_stop_next();
        t_stop_end();
        t_freeze();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule